// File: doc/BRIEF.md
# Frame-resynchronizing capture FIFO

This block sits between a capture-side word packer and a system bus reader. It holds eight 32-bit words in a circular store. A write pointer steps once per packed word accepted from the capture side. A read pointer steps once per word handed to the bus side. The read word appears on a registered output one cycle after the request is accepted.

The buffer does not apply back-pressure. A word written while all eight slots hold unread data replaces the oldest entry, and an overrun flag records the loss. The flag stays set until it is cleared by an explicit clear pulse.

When an overrun or a synchronization error is reported from outside, both pointers return to zero, which empties the buffer. Capture then closes and stays closed until a new frame-start pulse is seen. This keeps a partial frame from leaking into the next one. The same closed state applies after reset.

Top module: `cap_fifo_resync`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `empty`=1, `full`=0, `ovf_flag`=0, `capture_open`=0 and `rd_data`=0.
- R2: A write (`wr_valid`=1) is accepted only in a cycle where `capture_open` is 1. `capture_open` rises in the cycle after a `frame_start` pulse that has no flush request in the same cycle. While it is 0, writes leave the contents unchanged.
- R3: Accepted words are read back in the order they were written. A read is accepted when `rd_req`=1 and `empty`=0, and `rd_data` shows the oldest word from the next cycle on.
- R4: `empty` is 1 exactly when no unread word is held, and `full` is 1 exactly when eight unread words are held. Both are never 1 together.
- R5: A write accepted while `full`=1, with no read accepted in that cycle, discards the oldest word and stores the new one. `full` stays 1.
- R6: `ovf_flag` becomes 1 in the cycle after an R5 discard and holds until `ovf_clear` is pulsed. A discard in the same cycle as `ovf_clear` leaves the flag at 1.
- R7: A read request while `empty`=1 leaves `rd_data` unchanged and consumes nothing.
- R8: When `overrun_in`=1 or `sync_err`=1, the next cycle shows `empty`=1 and `capture_open`=0. In that cycle the flush takes precedence over a write, a read or a `frame_start`, and `rd_data` keeps its value.
- R9: When `full`=1 and both a write and a read are accepted in the same cycle, no word is lost, `full` stays 1 and `ovf_flag` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Packed word present on `wr_data` |
| wr_data | input | 32 | Packed capture word |
| rd_req | input | 1 | Bus side requests one word |
| rd_data | output | 32 | Last word read, registered |
| overrun_in | input | 1 | External overrun report, flushes the buffer |
| sync_err | input | 1 | Synchronization error report, flushes the buffer |
| frame_start | input | 1 | Start-of-frame pulse, reopens capture |
| ovf_clear | input | 1 | Clears the overrun flag |
| empty | output | 1 | No unread words |
| full | output | 1 | Eight unread words |
| ovf_flag | output | 1 | Sticky record of a discarded word |
| capture_open | output | 1 | Writes are currently accepted |

## Verification
A wrong pointer shows up at the ports through `empty` or `full` in the cycle after the faulty update. It also shows up as a wrong or reordered word on `rd_data` one cycle after the next accepted read. A gate that does not close or reopen correctly shows on `capture_open` within one cycle, and on `empty` after the first write that should or should not have landed. The reference model tracks the unread words in a queue and compares every output on every clock. Any divergence is therefore reported in the cycle it becomes visible, not at the end of a scenario.

// File: rtl/cap_fifo_pkg.sv
package cap_fifo_pkg;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;

    typedef struct packed {
        logic flush;
        logic wr;
        logic rd;
        logic drop;
    } fifo_op_t;

    function automatic fifo_op_t decode_op(
        input gate_e gate,
        input logic  wv,
        input logic  rq,
        input logic  flush_req,
        input logic  is_empty,
        input logic  is_full
    );
        fifo_op_t o;
        o.flush = flush_req;
        o.wr    = (gate == GATE_OPEN) && wv && !flush_req;
        o.rd    = rq && !is_empty && !flush_req;
        o.drop  = o.wr && is_full && !o.rd;
        return o;
    endfunction

    function automatic gate_e next_gate(
        input gate_e cur,
        input logic  flush_req,
        input logic  fs
    );
        if (flush_req) return GATE_SHUT;
        if (fs)        return GATE_OPEN;
        return cur;
    endfunction

    function automatic logic next_ovf(
        input logic cur,
        input logic drop,
        input logic clr
    );
        if (drop) return 1'b1;
        if (clr)  return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/cap_fifo_ctrl.sv
module cap_fifo_ctrl
    import cap_fifo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_valid,
    input  logic     rd_req,
    input  logic     overrun_in,
    input  logic     sync_err,
    input  logic     frame_start,
    input  logic     ovf_clear,
    input  logic     is_empty,
    input  logic     is_full,
    output fifo_op_t op,
    output logic     capture_open,
    output logic     ovf_flag
);
    gate_e gate_q;
    logic  ovf_q;
    logic  flush_req;

    assign flush_req = overrun_in || sync_err;

    always_comb begin
        op = decode_op(gate_q, wr_valid, rd_req, flush_req, is_empty, is_full);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= GATE_SHUT;
            ovf_q  <= 1'b0;
        end else begin
            gate_q <= next_gate(gate_q, flush_req, frame_start);
            ovf_q  <= next_ovf(ovf_q, op.drop, ovf_clear);
        end
    end

    assign capture_open = (gate_q == GATE_OPEN);
    assign ovf_flag     = ovf_q;
endmodule

// File: rtl/cap_fifo_ptrs.sv
module cap_fifo_ptrs
    import cap_fifo_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_op_t      op,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          is_empty,
    output logic          is_full
);
    logic [AW:0] wp_q;
    logic [AW:0] rp_q;
    logic [AW:0] one;

    assign one = {{AW{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || op.flush) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (op.wr)
                wp_q <= wp_q + one;
            if (op.rd || op.drop)
                rp_q <= rp_q + one;
        end
    end

    assign wr_addr  = wp_q[AW-1:0];
    assign rd_addr  = rp_q[AW-1:0];
    assign is_empty = (wp_q == rp_q);
    assign is_full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
endmodule

// File: rtl/cap_fifo_store.sv
module cap_fifo_store #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] slot_words [DEPTH];
    logic [W-1:0] rd_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(i)))
                word_q <= wr_data;
        end
        assign slot_words[i] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= slot_words[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/cap_fifo_resync.sv
module cap_fifo_resync
    import cap_fifo_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    input  logic             overrun_in,
    input  logic             sync_err,
    input  logic             frame_start,
    input  logic             ovf_clear,
    output logic             empty,
    output logic             full,
    output logic             ovf_flag,
    output logic             capture_open
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fifo_op_t      op;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          is_empty;
    logic          is_full;

    cap_fifo_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_valid     (wr_valid),
        .rd_req       (rd_req),
        .overrun_in   (overrun_in),
        .sync_err     (sync_err),
        .frame_start  (frame_start),
        .ovf_clear    (ovf_clear),
        .is_empty     (is_empty),
        .is_full      (is_full),
        .op           (op),
        .capture_open (capture_open),
        .ovf_flag     (ovf_flag)
    );

    cap_fifo_ptrs #(.AW(AW)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .is_empty (is_empty),
        .is_full  (is_full)
    );

    cap_fifo_store #(.W(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (op.wr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (op.rd),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign empty = is_empty;
    assign full  = is_full;
endmodule

// File: rtl/cap_fifo_resync_chk.sv
module cap_fifo_resync_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_valid,
    input logic         rd_req,
    input logic         overrun_in,
    input logic         sync_err,
    input logic         frame_start,
    input logic         ovf_clear,
    input logic         empty,
    input logic         full,
    input logic         ovf_flag,
    input logic         capture_open,
    input logic [W-1:0] rd_data
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (empty && !full && !ovf_flag && !capture_open && (rd_data == '0)));

    assert_closed_stays_empty_R2: assert property (@(posedge clk) disable iff (rst)
        (!capture_open && empty) |=> empty);

    assert_open_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !overrun_in && !sync_err) |=> capture_open);

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    assert_drop_keeps_full_R5: assert property (@(posedge clk) disable iff (rst)
        (full && wr_valid && capture_open && !rd_req && !overrun_in && !sync_err)
        |=> (full && ovf_flag));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clear) |=> ovf_flag);

    assert_empty_read_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty) |=> $stable(rd_data));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (overrun_in || sync_err) |=> (empty && !capture_open && $stable(rd_data)));

    assert_full_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (full && wr_valid && rd_req && capture_open && !overrun_in && !sync_err
         && !ovf_flag && !ovf_clear) |=> (full && !ovf_flag));
endmodule

bind cap_fifo_resync cap_fifo_resync_chk #(.W(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .rd_req       (rd_req),
    .overrun_in   (overrun_in),
    .sync_err     (sync_err),
    .frame_start  (frame_start),
    .ovf_clear    (ovf_clear),
    .empty        (empty),
    .full         (full),
    .ovf_flag     (ovf_flag),
    .capture_open (capture_open),
    .rd_data      (rd_data)
);

// File: tb/tb_cap_fifo_resync.sv
module tb_cap_fifo_resync;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid, rd_req, overrun_in, sync_err, frame_start, ovf_clear;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        empty, full, ovf_flag, capture_open;

    cap_fifo_resync dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .overrun_in(overrun_in),
        .sync_err(sync_err), .frame_start(frame_start), .ovf_clear(ovf_clear),
        .empty(empty), .full(full), .ovf_flag(ovf_flag), .capture_open(capture_open)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] mq [$];
    bit          m_open;
    bit          m_ovf;
    logic [31:0] m_rd;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;
    logic [31:0] nxt = 32'hA000_0000;

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    task automatic model_step();
        bit fl, rd, wr;
        fl = overrun_in || sync_err;
        if (fl) begin
            mq.delete();
            m_open = 0;
            if (ovf_clear) m_ovf = 0;
        end else begin
            rd = rd_req && (mq.size() > 0);
            wr = m_open && wr_valid;
            if (ovf_clear) m_ovf = 0;
            if (rd) m_rd = mq.pop_front();
            if (wr) begin
                if (!rd && mq.size() == DEPTH) begin
                    void'(mq.pop_front());
                    m_ovf = 1;
                end
                mq.push_back(wr_data);
            end
            if (frame_start) m_open = 1;
        end
    endtask

    task automatic compare_all();
        chk("R4", "empty", 32'(empty), 32'(mq.size() == 0));
        chk("R4", "full", 32'(full), 32'(mq.size() == DEPTH));
        chk("R3", "rd_data", rd_data, m_rd);
        chk("R6", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
        chk("R2", "capture_open", 32'(capture_open), 32'(m_open));
    endtask

    task automatic step(bit wv, bit rq, bit ov, bit se, bit fs, bit clr);
        wr_valid = wv; wr_data = nxt; rd_req = rq; overrun_in = ov;
        sync_err = se; frame_start = fs; ovf_clear = clr;
        if (wv) nxt = nxt + 32'h11;
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/4);
        compare_all();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R3 watchdog got=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        logic [31:0] first_kept;
        rst = 1; wr_valid = 0; wr_data = 0; rd_req = 0; overrun_in = 0;
        sync_err = 0; frame_start = 0; ovf_clear = 0;
        m_open = 0; m_ovf = 0; m_rd = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "empty", 32'(empty), 1);
        chk("R1", "full", 32'(full), 0);
        chk("R1", "ovf_flag", 32'(ovf_flag), 0);
        chk("R1", "capture_open", 32'(capture_open), 0);
        chk("R1", "rd_data", rd_data, 0);
        rst = 0;

        // R2: writes before frame start are ignored
        repeat (3) step(1, 0, 0, 0, 0, 0);
        chk("R2", "empty after closed writes", 32'(empty), 1);
        step(0, 0, 0, 0, 1, 0);
        chk("R2", "open after frame start", 32'(capture_open), 1);

        // R3: ordered write and read with gaps
        repeat (5) step(1, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        repeat (5) step(0, 1, 0, 0, 0, 0);

        // R7: read while empty keeps data
        held = rd_data;
        repeat (3) step(0, 1, 0, 0, 0, 0);
        chk("R7", "rd_data held", rd_data, held);
        chk("R7", "still empty", 32'(empty), 1);

        // R5/R6: fill, overwrite three times
        first_kept = nxt + 32'h33;
        repeat (DEPTH) step(1, 0, 0, 0, 0, 0);
        chk("R4", "full at eight", 32'(full), 1);
        repeat (3) step(1, 0, 0, 0, 0, 0);
        chk("R5", "full kept", 32'(full), 1);
        chk("R6", "flag set", 32'(ovf_flag), 1);
        step(0, 1, 0, 0, 0, 0);
        chk("R5", "oldest surviving word", rd_data, first_kept);
        repeat (7) step(0, 1, 0, 0, 0, 0);
        chk("R6", "flag held", 32'(ovf_flag), 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R6", "flag cleared", 32'(ovf_flag), 0);

        // R6: drop coinciding with clear keeps flag
        repeat (DEPTH) step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 1);
        chk("R6", "set beats clear", 32'(ovf_flag), 1);
        step(0, 0, 0, 0, 0, 1);

        // R9: full with simultaneous read and write
        repeat (4) step(1, 1, 0, 0, 0, 0);
        chk("R9", "full kept", 32'(full), 1);
        chk("R9", "no overrun", 32'(ovf_flag), 0);

        // R8: flush beats frame start, write and read
        held = rd_data;
        step(1, 1, 1, 0, 1, 0);
        chk("R8", "empty after flush", 32'(empty), 1);
        chk("R8", "gate shut", 32'(capture_open), 0);
        chk("R8", "rd_data kept", rd_data, held);
        repeat (2) step(1, 0, 0, 0, 0, 0);
        chk("R8", "writes ignored after flush", 32'(empty), 1);
        step(0, 0, 0, 0, 1, 0);
        repeat (3) step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        chk("R8", "sync error flush", 32'(empty), 1);
        chk("R8", "sync error shuts gate", 32'(capture_open), 0);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r < 60, $urandom_range(0, 99) < 45, r == 97, r == 98,
                 (r % 17) == 3, (r % 23) == 5);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule